// File: doc/BRIEF.md
# Symmetric Pre-Add Interleaved FIR Filter

This block is a one-dimensional FIR filter for 12-bit two's complement samples. Samples enter a forward chain of tap stages. The last forward stage feeds a reverse chain that runs back the other way. Each tap stage is a delay whose depth can be set from 1 to 16. When several data streams are interleaved sample by sample, each stream therefore sees only its own history, with no need to split the streams apart.

For each coefficient pair, one pre-add unit combines a forward-chain sample with the reverse-chain sample that mirrors it. The combination is the sum, the difference, or a single operand with the other forced to zero. Eight multipliers can therefore serve a 16-tap symmetric kernel or an 8-tap asymmetric one. A registered coefficient row address picks one of 256 stored rows of eight coefficients. A plain write port fills those rows.

The eight products are summed at full precision. The sum then goes to an accumulator controlled by a per-sample flag. This lets a decimating filter spend the cycles between output reads on extra taps.

Top module: `symfold_fir`

## Requirements
- R1: Samples and coefficients are 12-bit two's complement. For each item the filter forms S = sum over k = 0..7 of c_k * P_k at full precision. c_k is the coefficient in pair slot k of the selected row, and P_k is the pre-add output of pair k. The result port is 32 bits wide, two's complement, and wraps modulo 2^32.
- R2: When `alu_sub` is 0, P_k = A_k + B_k (even-symmetric kernels). When `alu_sub` is 1, P_k = B_k - A_k (odd-symmetric kernels). P_k is 13 bits wide, so the extreme inputs do not overflow.
- R3: When `zero_a` is 1, A_k is replaced by 0 in every pair. When `zero_b` is 1, B_k is replaced by 0. With `zero_b` set, an impulse yields exactly 8 nonzero results.
- R4: Let x[n] be the most recently accepted sample, and let L be the stage length. The forward operand is A_k = x[n - k*L] and the mirrored operand is B_k = x[n - (15 - k)*L]. Samples older than the last reset read as 0. With both operands enabled, an impulse yields exactly 16 nonzero results.
- R5: Each tap stage delays by L = `stage_len` + 1 accepted samples, so codes 0 to 15 give lengths 1 to 16.
- R6: `shift_en_n` is active low. When it is low at a clock edge, the input register takes `sample_in` and every stage of both chains shifts by one. When it is high, the input register and all chain contents hold.
- R7: The coefficient row register loads `coef_row` at a clock edge only when `coef_row_en_n` is low, and holds otherwise. The 8-bit row selects one of 256 rows. It applies to the sample accepted at that same edge.
- R8: Let `acc_hold` be sampled together with an item. If the flag is 1, the accumulator adds that item's S and the result holds. If the flag is 0, the result loads the accumulator total and the accumulator restarts from that item's S. Asserting the flag on N-1 of every N items gives one result per N items, covering 16N tap positions.
- R9: Take a sample and an address presented before clock edge e, with `acc_hold` kept 0. The sum of that item appears on `result` right after edge e + 5.
- R10: The synchronous active-low reset clears both chains, the input register, the row register, the pipeline, the accumulator and the result. Stored coefficients keep their values, and the write port works during reset.
- R11: When `coef_we` is 1 at a clock edge, `coef_wdata` is stored in row `coef_wrow`, pair slot `coef_wsel`. Slot k is the coefficient for pair k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_in | input | 12 | Input sample, two's complement |
| shift_en_n | input | 1 | Active-low load and shift enable for the input register and both chains |
| acc_hold | input | 1 | 1: accumulate this item; 0: output the total and restart |
| coef_row | input | 8 | Coefficient row address |
| coef_row_en_n | input | 1 | Active-low load enable for the row address register |
| alu_sub | input | 1 | Pre-add operation: 0 gives A+B, 1 gives B-A |
| zero_a | input | 1 | Force the forward operand to zero |
| zero_b | input | 1 | Force the mirrored operand to zero |
| stage_len | input | 4 | Tap stage length minus one |
| coef_we | input | 1 | Coefficient write strobe |
| coef_wrow | input | 8 | Row to write |
| coef_wsel | input | 3 | Pair slot to write |
| coef_wdata | input | 12 | Coefficient value, two's complement |
| result | output | 32 | Accumulated filter result |

## Verification
The bench feeds single impulses and counts the nonzero outputs. A chain miswired from forward to reverse, or a mirror pair off by one stage, changes the count away from 16 (or 8 with one operand forced off), and a wrong pipeline depth moves the first nonzero output away from its fifth cycle. Long random streams at stage lengths 3 and 16 expose a depth decoded one off, because the far taps then pick up the wrong history. Further streams run with random shift holds, random row changes with the enable both asserted and deasserted, full-scale samples of both signs under subtraction, and a four-way decimation pattern. These catch a chain that keeps moving while held, an address taken while its enable is off, a 12-bit pre-add that overflows, and an accumulator that releases its total on the wrong flag level.

// File: rtl/sf_pkg.sv
// Shared constants and types for the symmetric pre-add FIR.
// Assumes: all arithmetic is two's complement.
package sf_pkg;
    localparam int SF_DATA_W  = 12;
    localparam int SF_COEF_W  = 12;
    localparam int SF_PAIRS   = 8;
    localparam int SF_MAX_LEN = 16;
    localparam int SF_ROWS    = 256;
    localparam int SF_ACC_W   = 32;

    // Pre-add operation select
    typedef enum logic {
        PA_SUM  = 1'b0,
        PA_DIFF = 1'b1
    } preadd_op_e;
endpackage

// File: rtl/sf_tap_delay.sv
// One tap stage: a shift register of DEPTH words with a selectable output depth.
// Assumes: len_sel = L-1, so the output is the input delayed by L accepted shifts.
module sf_tap_delay #(
    parameter int W     = 12,
    parameter int DEPTH = 16,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [SEL_W-1:0] len_sel,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);
    logic [W-1:0] sr [DEPTH];

    // Shift the stage contents by one word on each enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else if (shift_en) begin
            sr[0] <= din;
            for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
    end

    assign dout = sr[len_sel];
endmodule

// File: rtl/sf_preadd.sv
// Pre-add unit for one coefficient pair: A+B, B-A, or one operand with the other zeroed.
// Assumes: the output is one bit wider than the operands, so no result overflows.
module sf_preadd
    import sf_pkg::*;
#(
    parameter int W = 12
) (
    input  preadd_op_e         op,
    input  logic               zero_a,
    input  logic               zero_b,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W:0]   p
);
    logic signed [W:0] ea;
    logic signed [W:0] eb;

    // Gate and sign-extend the operands, then apply the selected operation
    always_comb begin
        ea = zero_a ? '0 : (W+1)'(a);
        eb = zero_b ? '0 : (W+1)'(b);
        p  = (op == PA_DIFF) ? (eb - ea) : (ea + eb);
    end
endmodule

// File: rtl/sf_coef_bank.sv
// Coefficient store: ROWS rows of PAIRS coefficients, one write port, and a registered row read.
// Assumes: contents are not reset; writes are accepted in any reset state.
module sf_coef_bank #(
    parameter int CW    = 12,
    parameter int PAIRS = 8,
    parameter int ROWS  = 256,
    localparam int ROW_W = $clog2(ROWS),
    localparam int SEL_W = $clog2(PAIRS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ROW_W-1:0]    wrow,
    input  logic [SEL_W-1:0]    wsel,
    input  logic [CW-1:0]       wdata,
    input  logic [ROW_W-1:0]    rrow,
    output logic [PAIRS*CW-1:0] rdata
);
    logic [CW-1:0] mem [ROWS][PAIRS];

    // Store one coefficient per write strobe
    always_ff @(posedge clk) begin
        if (we) mem[wrow][wsel] <= wdata;
    end

    // Register the full row selected by the row address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            for (int k = 0; k < PAIRS; k++) rdata[k*CW +: CW] <= mem[rrow][k];
        end
    end
endmodule

// File: rtl/sf_mac_tree.sv
// Multiplies each registered pre-add value by its coefficient and sums all products.
// Two register stages: products, then the full-precision sum.
module sf_mac_tree #(
    parameter int PW    = 13,
    parameter int CW    = 12,
    parameter int PAIRS = 8,
    localparam int PROD_W = PW + CW,
    localparam int SUM_W  = PROD_W + $clog2(PAIRS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PAIRS*PW-1:0]       pre_flat,
    input  logic [PAIRS*CW-1:0]       coef_flat,
    output logic signed [SUM_W-1:0]   sum
);
    logic signed [PW-1:0]     pre_s  [PAIRS];
    logic signed [CW-1:0]     coef_s [PAIRS];
    logic signed [PROD_W-1:0] prod_q [PAIRS];
    logic signed [SUM_W-1:0]  tot;

    for (genvar k = 0; k < PAIRS; k++) begin : g_unpack
        assign pre_s[k]  = pre_flat[k*PW +: PW];
        assign coef_s[k] = coef_flat[k*CW +: CW];
    end

    // Register one signed product per pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < PAIRS; k++) prod_q[k] <= '0;
        end else begin
            for (int k = 0; k < PAIRS; k++) prod_q[k] <= pre_s[k] * coef_s[k];
        end
    end

    // Add all products at full width
    always_comb begin
        tot = '0;
        for (int k = 0; k < PAIRS; k++) tot = tot + prod_q[k];
    end

    // Register the sum
    always_ff @(posedge clk) begin
        if (!rst_n) sum <= '0;
        else        sum <= tot;
    end
endmodule

// File: rtl/symfold_fir.sv
// Symmetric pre-add interleaved FIR: input register, forward and reverse tap chains,
// pre-add units, coefficient store, multiply-sum pipeline and output accumulator.
// Assumes: configuration inputs are held steady while data flows.
// Latency: an item accepted at edge e reaches the accumulator at edge e+4.
module symfold_fir
    import sf_pkg::*;
#(
    parameter int DATA_W  = SF_DATA_W,
    parameter int COEF_W  = SF_COEF_W,
    parameter int PAIRS   = SF_PAIRS,
    parameter int MAX_LEN = SF_MAX_LEN,
    parameter int ROWS    = SF_ROWS,
    parameter int ACC_W   = SF_ACC_W,
    localparam int LEN_W  = $clog2(MAX_LEN),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int SEL_W  = $clog2(PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_in,
    input  logic              shift_en_n,
    input  logic              acc_hold,
    input  logic [ROW_W-1:0]  coef_row,
    input  logic              coef_row_en_n,
    input  logic              alu_sub,
    input  logic              zero_a,
    input  logic              zero_b,
    input  logic [LEN_W-1:0]  stage_len,
    input  logic              coef_we,
    input  logic [ROW_W-1:0]  coef_wrow,
    input  logic [SEL_W-1:0]  coef_wsel,
    input  logic [COEF_W-1:0] coef_wdata,
    output logic [ACC_W-1:0]  result
);
    localparam int PRE_W   = DATA_W + 1;
    localparam int SUM_W   = PRE_W + COEF_W + $clog2(PAIRS);
    localparam int CTL_DLY = 4;

    logic [DATA_W-1:0]        din_q;
    logic [ROW_W-1:0]         row_q;
    logic [CTL_DLY-1:0]       acc_pipe;
    logic [DATA_W-1:0]        fwd_in  [PAIRS];
    logic [DATA_W-1:0]        fwd_out [PAIRS];
    logic [DATA_W-1:0]        rev_in  [PAIRS];
    logic signed [PRE_W-1:0]  pre     [PAIRS];
    logic [PAIRS*PRE_W-1:0]   pre_flat_q;
    logic [PAIRS*COEF_W-1:0]  coef_flat;
    logic signed [SUM_W-1:0]  sum;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  res_q;
    logic                     shift_en;
    preadd_op_e               op;

    assign shift_en = !shift_en_n;
    assign op       = preadd_op_e'(alu_sub);

    // Input sample register, gated by the shift enable
    always_ff @(posedge clk) begin
        if (!rst_n)        din_q <= '0;
        else if (shift_en) din_q <= sample_in;
    end

    // Coefficient row address register, gated by its own enable
    always_ff @(posedge clk) begin
        if (!rst_n)              row_q <= '0;
        else if (!coef_row_en_n) row_q <= coef_row;
    end

    // Carry the accumulate flag alongside its item down the pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) acc_pipe <= '0;
        else        acc_pipe <= {acc_pipe[CTL_DLY-2:0], acc_hold};
    end

    // Forward chain: each stage feeds the next; stage 0 takes the input register
    for (genvar k = 0; k < PAIRS; k++) begin : g_fwd
        if (k == 0) begin : g_head
            assign fwd_in[k] = din_q;
        end else begin : g_link
            assign fwd_in[k] = fwd_out[k-1];
        end
        sf_tap_delay #(.W(DATA_W), .DEPTH(MAX_LEN)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .len_sel  (stage_len),
            .din      (fwd_in[k]),
            .dout     (fwd_out[k])
        );
    end

    // Reverse chain: the last forward output turns back through PAIRS-1 stages
    assign rev_in[PAIRS-1] = fwd_out[PAIRS-1];
    for (genvar k = 1; k < PAIRS; k++) begin : g_rev
        sf_tap_delay #(.W(DATA_W), .DEPTH(MAX_LEN)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .len_sel  (stage_len),
            .din      (rev_in[k]),
            .dout     (rev_in[k-1])
        );
    end

    // One pre-add unit per pair: forward tap k against its mirror in the reverse chain
    for (genvar k = 0; k < PAIRS; k++) begin : g_alu
        sf_preadd #(.W(DATA_W)) u_alu (
            .op     (op),
            .zero_a (zero_a),
            .zero_b (zero_b),
            .a      (fwd_in[k]),
            .b      (rev_in[k]),
            .p      (pre[k])
        );
    end

    // Register the pre-add outputs, aligned with the registered coefficient row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_flat_q <= '0;
        end else begin
            for (int k = 0; k < PAIRS; k++) pre_flat_q[k*PRE_W +: PRE_W] <= pre[k];
        end
    end

    sf_coef_bank #(.CW(COEF_W), .PAIRS(PAIRS), .ROWS(ROWS)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (coef_we),
        .wrow  (coef_wrow),
        .wsel  (coef_wsel),
        .wdata (coef_wdata),
        .rrow  (row_q),
        .rdata (coef_flat)
    );

    sf_mac_tree #(.PW(PRE_W), .CW(COEF_W), .PAIRS(PAIRS)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_flat  (pre_flat_q),
        .coef_flat (coef_flat),
        .sum       (sum)
    );

    // Accumulate while the flag is set; otherwise release the total and restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
        end else if (acc_pipe[CTL_DLY-1]) begin
            acc_q <= acc_q + ACC_W'(sum);
        end else begin
            res_q <= acc_q;
            acc_q <= ACC_W'(sum);
        end
    end

    assign result = res_q;
endmodule

// File: rtl/sf_checker.sv
// Property checker for symfold_fir, attached by bind.
module sf_checker #(
    parameter int DATA_W = 12,
    parameter int ROW_W  = 8,
    parameter int ACC_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_en_n,
    input logic [DATA_W-1:0] sample_in,
    input logic [DATA_W-1:0] din_q,
    input logic              coef_row_en_n,
    input logic [ROW_W-1:0]  coef_row,
    input logic [ROW_W-1:0]  row_q,
    input logic              acc_now,
    input logic [ACC_W-1:0]  result
);
    // R6
    hold_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_n |=> $stable(din_q));

    // R6
    load_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_n |=> (din_q == $past(sample_in)));

    // R7
    row_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_row_en_n |=> (row_q == $past(coef_row)));

    // R7
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coef_row_en_n |=> $stable(row_q));

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_now |=> $stable(result));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && row_q == '0 && din_q == '0));
endmodule

bind symfold_fir sf_checker #(.DATA_W(DATA_W), .ROW_W(ROW_W), .ACC_W(ACC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .shift_en_n    (shift_en_n),
    .sample_in     (sample_in),
    .din_q         (din_q),
    .coef_row_en_n (coef_row_en_n),
    .coef_row      (coef_row),
    .row_q         (row_q),
    .acc_now       (acc_pipe[CTL_DLY-1]),
    .result        (result)
);

// File: tb/sim_symfold_fir.sv
module sim_symfold_fir;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] sample_in;
    logic        shift_en_n, acc_hold, coef_row_en_n;
    logic [7:0]  coef_row;
    logic        alu_sub, zero_a, zero_b;
    logic [3:0]  stage_len;
    logic        coef_we;
    logic [7:0]  coef_wrow;
    logic [2:0]  coef_wsel;
    logic [11:0] coef_wdata;
    logic [31:0] result;

    always #2 clk = ~clk;

    symfold_fir u0 (
        .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .shift_en_n(shift_en_n),
        .acc_hold(acc_hold), .coef_row(coef_row), .coef_row_en_n(coef_row_en_n),
        .alu_sub(alu_sub), .zero_a(zero_a), .zero_b(zero_b), .stage_len(stage_len),
        .coef_we(coef_we), .coef_wrow(coef_wrow), .coef_wsel(coef_wsel),
        .coef_wdata(coef_wdata), .result(result)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    int    exp_q[$];

    // reference state
    int coef_m [256][8];
    int hist [4096];
    int hcnt, row_m, acc_m, res_m, m_len;
    int pS [4];
    bit pa [4];
    bit m_sub, m_za, m_zb;
    int rows [4] = '{0, 1, 37, 255};

    // impulse observation
    bit nz_on;
    int nz_cnt, first_nz, first_val, step_idx;

    function automatic int hat(int d);
        return (d < hcnt) ? hist[hcnt-1-d] : 0;
    endfunction

    // R1 R2 R3 R4: expected full-precision sum for the current state
    function automatic int model_sum();
        int s, a, b, p;
        s = 0;
        for (int k = 0; k < 8; k++) begin
            a = m_za ? 0 : hat(k * m_len);
            b = m_zb ? 0 : hat((15 - k) * m_len);
            p = m_sub ? (b - a) : (a + b);
            s += coef_m[row_m][k] * p;
        end
        return s;
    endfunction

    function automatic int rs();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compare each produced result against the scoreboard
    always @(negedge clk) begin
        int e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (int'($signed(result)) != e) begin
                errors++;
                $display("FAIL %s: actual=%0d expected=%0d", cur_req, int'($signed(result)), e);
            end
        end
    end

    // driver: one clock of stimulus, and the result expected after that edge (R8 R9)
    task automatic step(input int x, input bit sh_n, input bit acc, input bit ren_n, input int row);
        sample_in     = 12'(x);
        shift_en_n    = sh_n;
        acc_hold      = acc;
        coef_row_en_n = ren_n;
        coef_row      = 8'(row);
        @(posedge clk);
        if (pa[3]) acc_m += pS[3];
        else begin
            res_m = acc_m;
            acc_m = pS[3];
        end
        for (int i = 3; i > 0; i--) begin
            pS[i] = pS[i-1];
            pa[i] = pa[i-1];
        end
        if (!sh_n) begin
            hist[hcnt] = x;
            hcnt++;
        end
        if (!ren_n) row_m = row;
        pS[0] = model_sum();
        pa[0] = acc;
        exp_q.push_back(res_m);
        @(negedge clk);
        if (nz_on && result != 0) begin
            nz_cnt++;
            if (first_nz < 0) begin
                first_nz  = step_idx;
                first_val = int'($signed(result));
            end
        end
        step_idx++;
    endtask

    // R10: reset with a new configuration; the reference restarts from zero state
    task automatic do_reset(input bit sub, input bit za, input bit zb, input int len);
        rst_n = 1'b0;
        alu_sub = sub; zero_a = za; zero_b = zb; stage_len = 4'(len - 1);
        shift_en_n = 1'b1; acc_hold = 1'b0; coef_row_en_n = 1'b1;
        m_sub = sub; m_za = za; m_zb = zb; m_len = len;
        repeat (3) @(negedge clk);
        hcnt = 0; row_m = 0; acc_m = 0; res_m = 0;
        for (int i = 0; i < 4; i++) begin
            pS[i] = 0;
            pa[i] = 1'b0;
        end
        rst_n = 1'b1;
        chk("R10", int'(result), 0);
    endtask

    task automatic impulse(input int n);
        nz_on = 1'b1; nz_cnt = 0; first_nz = -1; first_val = 0; step_idx = 0;
        step(1, 1'b0, 1'b0, 1'b0, 0);
        for (int i = 0; i < n; i++) step(0, 1'b0, 1'b0, 1'b1, 0);
        nz_on = 1'b0;
    endtask

    task automatic run_rand(input int n, input int hold_pct, input int dec);
        for (int i = 0; i < n; i++) begin
            step(rs(), ($urandom_range(0, 99) < hold_pct),
                 (dec > 1) ? ((i % dec) != 0) : 1'b0,
                 ($urandom_range(0, 3) != 0), rows[$urandom_range(0, 3)]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sample_in = '0; shift_en_n = 1'b1; acc_hold = 1'b0;
        coef_row = '0; coef_row_en_n = 1'b1; alu_sub = 1'b0; zero_a = 1'b0;
        zero_b = 1'b0; stage_len = '0; coef_we = 1'b0; coef_wrow = '0;
        coef_wsel = '0; coef_wdata = '0; nz_on = 1'b0;
        for (int r = 0; r < 256; r++)
            for (int k = 0; k < 8; k++) coef_m[r][k] = 0;
        @(negedge clk);
        // R11: load four rows while reset is held
        for (int ri = 0; ri < 4; ri++) begin
            for (int k = 0; k < 8; k++) begin
                int v;
                if (rows[ri] == 0)        v = (k + 1) * 37;
                else if (rows[ri] == 255) v = (k % 2 == 0) ? -2048 : 2047;
                else                      v = rs();
                coef_we = 1'b1; coef_wrow = 8'(rows[ri]); coef_wsel = 3'(k); coef_wdata = 12'(v);
                @(negedge clk);
                coef_m[rows[ri]][k] = v;
            end
        end
        coef_we = 1'b0;

        // R4 R9: impulse through the symmetric 16-tap form
        cur_req = "R4";
        do_reset(1'b0, 1'b0, 1'b0, 1);
        impulse(30);
        chk("R4", nz_cnt, 16);
        chk("R9", first_nz, 5);
        chk("R9", first_val, 37);

        // R3: asymmetric form gives 8 taps
        cur_req = "R3";
        do_reset(1'b0, 1'b0, 1'b1, 1);
        impulse(30);
        chk("R3", nz_cnt, 8);
        do_reset(1'b0, 1'b1, 1'b0, 1);
        run_rand(60, 0, 1);

        // R1 R7 R11: random stream with row switching through the enabled and held address
        cur_req = "R7";
        do_reset(1'b0, 1'b0, 1'b0, 1);
        run_rand(80, 0, 1);

        // R2: odd-symmetric difference
        cur_req = "R2";
        do_reset(1'b1, 1'b0, 1'b0, 1);
        impulse(30);
        chk("R2", nz_cnt, 16);
        run_rand(60, 0, 1);

        // R5: interleave depths 3 and 16
        cur_req = "R5";
        do_reset(1'b0, 1'b0, 1'b0, 3);
        run_rand(100, 0, 1);
        do_reset(1'b1, 1'b0, 1'b0, 16);
        run_rand(300, 0, 1);

        // R6: random shift holds
        cur_req = "R6";
        do_reset(1'b0, 1'b0, 1'b0, 2);
        run_rand(120, 40, 1);

        // R8: decimate by four through the accumulator
        cur_req = "R8";
        do_reset(1'b0, 1'b0, 1'b0, 4);
        run_rand(160, 0, 4);

        // R1: full-scale samples of both signs with extreme coefficients
        cur_req = "R1";
        do_reset(1'b1, 1'b0, 1'b0, 1);
        step(2047, 1'b0, 1'b0, 1'b0, 255);
        for (int i = 0; i < 40; i++) step((i % 3 == 0) ? 2047 : -2048, 1'b0, 1'b0, 1'b1, 0);

        // R10: reset mid-stream clears state, stored coefficients survive
        cur_req = "R10";
        do_reset(1'b0, 1'b0, 1'b0, 1);
        impulse(30);
        chk("R10", first_val, 37);
        run_rand(40, 10, 1);

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule